// File: doc/BRIEF.md
# IDE PIO Sector Read Sequencer

This block sits on the host side of a 16-bit IDE or CompactFlash task-file bus. It reads one 512-byte sector in programmed-I/O mode. Before it takes any work, it brings the device up by itself after reset. It pulses the device reset pin and waits for a settling delay. It then selects the master device in block-addressed mode and polls until the device stops reporting busy. Once that succeeds, the block raises `req_ready`.

A request carries a track number and a sector number. The block folds them into a 16-bit block address, programs the address and count registers, and waits for the device to report ready. It then issues the read command, waits for a data request, and reads 256 words. Each word leaves on a byte stream with a valid/ready handshake, low byte first. After the last word the block reads status once more. Every request ends with a single `done` pulse that carries an error flag.

The controller is one state machine. Its states are: `S_RST_PULSE` → `S_RST_WAIT` → `S_LOGIN_SDH` → `S_LOGIN_POLL`. From `S_LOGIN_POLL` it goes to `S_IDLE` when busy clears, or to `S_DEAD` when the poll budget runs out. From `S_IDLE` a request leads to `S_PROG`, which makes four register writes, then to `S_WAIT_RDY`. That state goes to `S_CMD` when status shows ready, or to `S_DONE` with an error on timeout. `S_CMD` goes to `S_WAIT_DRQ`, which goes to `S_RD_WORD` on a data request, or to `S_DONE` with an error on timeout. Each word then passes `S_RD_WORD` → `S_EMIT_LO` → `S_EMIT_HI`. After `S_EMIT_HI` the machine returns to `S_RD_WORD`, or goes to `S_FINAL_STAT` after word 255. `S_FINAL_STAT` goes to `S_DONE`, and `S_DONE` returns to `S_IDLE`. Each register access runs through an address, strobe, hold and clear phase in a separate bus-cycle unit.

Top module: `ide_sector_reader`

## Requirements
- R1: After reset, `ide_rst` is high for exactly RST_CYC cycles. After POST_RST_CYC more cycles, the block writes 0xE0 to drive/head (chip select 0, address 6). It then reads status (chip select 0, address 7) until bit 7 is 0, and only then raises `req_ready`.
- R2: If bit 7 of status stays 1 for LOGIN_POLLS polls during bring-up, `login_fail` goes high for good and `req_ready` stays low.
- R3: The block address is track[7:0]×64 + sector, and track[15:8] has no effect. The block writes, in this order: 0x00 to cylinder high (address 5), the address high byte to cylinder low (address 4), the address low byte to sector number (address 3), and 0x01 to sector count (address 2).
- R4: The read command 0x20 is written to address 7 only after a status read shows bits 7:6 = 01. If POLL_MAX polls fail, no command is written and the request ends with `done_err`=1.
- R5: After the command, status is polled until bit 7 = 0 and bit 3 = 1, and only then is the data register (address 0) read. If POLL_MAX polls fail, no data is read and the request ends with `done_err`=1.
- R6: A good transfer makes 256 data-register reads and sends 512 bytes, each word's bits 7:0 before its bits 15:8.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold. While a byte is waiting, neither read nor write strobe is active.
- R8: After the last word, status is read once. `done_err` is then equal to its bit 0.
- R9: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. Each accepted request gives exactly one one-cycle `done` pulse. `req_valid` has no effect while the block is busy.
- R10: In every access, a chip select and the address are driven before the strobe. Each strobe lasts STB_CYC cycles. The chip select and address stay driven for STB_CYC cycles after the strobe falls, and only then is every control line cleared. Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_track | input | TRK_W | Requested track (only the low 8 bits count) |
| req_sector | input | SEC_W | Requested sector within the track |
| req_ready | output | 1 | High in idle after a good bring-up |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error flag, valid with `done` |
| login_fail | output | 1 | Bring-up poll ran out |
| out_valid | output | 1 | Byte on `out_byte` is valid |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Sector data byte |
| ide_addr | output | 3 | Task-file address A2..A0 |
| ide_cs0 | output | 1 | Command-block chip select, active high |
| ide_cs1 | output | 1 | Control-block chip select, active high |
| ide_rd | output | 1 | Read strobe, active high |
| ide_wr | output | 1 | Write strobe, active high |
| ide_rst | output | 1 | Device reset, active high |
| ide_dout | output | 16 | Write data toward the device |
| ide_doe | output | 1 | Enable for the data driver |
| ide_din | input | 16 | Read data from the device |

## Verification
The assertions assume that `out_ready` and `req_valid` change only between clock edges. They also assume that `ide_din` settles while the read strobe is high. The bench's device model meets both: it drives read data as a function of the strobed address, and it updates its counters only on strobe falling edges. `out_ready` changes only through non-blocking updates at the rising edge. Status sequences are chosen so that every poll count lands either well inside POLL_MAX or beyond it, never exactly at the boundary by accident. Bring-up is run twice: once with a device that answers at once, and once with one that never clears busy.

// File: rtl/ide_rd_pkg.sv
package ide_rd_pkg;

    typedef enum logic [3:0] {
        S_RST_PULSE,
        S_RST_WAIT,
        S_LOGIN_SDH,
        S_LOGIN_POLL,
        S_DEAD,
        S_IDLE,
        S_PROG,
        S_WAIT_RDY,
        S_CMD,
        S_WAIT_DRQ,
        S_RD_WORD,
        S_EMIT_LO,
        S_EMIT_HI,
        S_FINAL_STAT,
        S_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_STRB,
        PH_HOLD,
        PH_CLR
    } bus_phase_t;

    typedef struct packed {
        logic        wr;
        logic        alt;
        logic [2:0]  a;
        logic [15:0] wdata;
    } bus_req_t;

    localparam logic [2:0] TF_DATA   = 3'd0;
    localparam logic [2:0] TF_SECCNT = 3'd2;
    localparam logic [2:0] TF_SECNUM = 3'd3;
    localparam logic [2:0] TF_CYLLO  = 3'd4;
    localparam logic [2:0] TF_CYLHI  = 3'd5;
    localparam logic [2:0] TF_DRVHD  = 3'd6;
    localparam logic [2:0] TF_CMDST  = 3'd7;

    localparam logic [7:0] OP_READ_SECT  = 8'h20;
    localparam logic [7:0] DRVHD_MASTER  = 8'hE0;

    localparam int ST_BSY = 7;
    localparam int ST_RDY = 6;
    localparam int ST_DRQ = 3;
    localparam int ST_ERR = 0;

endpackage

// File: rtl/ide_lba_map.sv
module ide_lba_map #(
    parameter int TRK_LOW_W = 8,
    parameter int SPT_LOG2  = 6,
    parameter int SEC_W     = 8,
    parameter int LBA_W     = 16
) (
    input  logic [TRK_LOW_W-1:0] trk_low,
    input  logic [SEC_W-1:0]     sec,
    output logic [LBA_W-1:0]     lba
);
    always_comb begin
        lba = (LBA_W'(trk_low) << SPT_LOG2) + LBA_W'(sec);
    end
endmodule

// File: rtl/ide_bus_cycle.sv
module ide_bus_cycle
    import ide_rd_pkg::*;
#(
    parameter int STB_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  bus_req_t    req,
    output logic [15:0] rdata,
    output logic        done,
    output logic [2:0]  ide_addr,
    output logic        ide_cs0,
    output logic        ide_cs1,
    output logic        ide_rd,
    output logic        ide_wr,
    output logic [15:0] ide_dout,
    output logic        ide_doe,
    input  logic [15:0] ide_din
);
    localparam int PW = $clog2(STB_CYC + 1);

    bus_phase_t     phase;
    logic [PW-1:0]  pcnt;
    bus_req_t       held;
    logic           last;
    logic           drive;

    assign last = (pcnt == PW'(STB_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            pcnt  <= '0;
            held  <= '0;
            rdata <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        held  <= req;
                        phase <= PH_ADDR;
                        pcnt  <= '0;
                    end
                end
                PH_ADDR: begin
                    pcnt <= last ? '0 : pcnt + PW'(1);
                    if (last) phase <= PH_STRB;
                end
                PH_STRB: begin
                    pcnt <= last ? '0 : pcnt + PW'(1);
                    if (last) begin
                        phase <= PH_HOLD;
                        if (!held.wr) rdata <= ide_din;
                    end
                end
                PH_HOLD: begin
                    pcnt <= last ? '0 : pcnt + PW'(1);
                    if (last) phase <= PH_CLR;
                end
                PH_CLR:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        drive    = (phase == PH_ADDR) || (phase == PH_STRB) || (phase == PH_HOLD);
        ide_addr = drive ? held.a : 3'd0;
        ide_cs0  = drive && !held.alt;
        ide_cs1  = drive && held.alt;
        ide_rd   = (phase == PH_STRB) && !held.wr;
        ide_wr   = (phase == PH_STRB) && held.wr;
        ide_doe  = drive && held.wr;
        ide_dout = ide_doe ? held.wdata : 16'h0000;
        done     = (phase == PH_CLR);
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(ide_rd && ide_wr)); // R10
    AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (ide_rd || ide_wr) |-> (ide_cs0 || ide_cs1)); // R10
    AST_RELEASE_BEFORE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ide_rd) || $fell(ide_wr)) |-> ((ide_cs0 || ide_cs1) && $stable(ide_addr))); // R10
    AST_SELECT_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ide_rd) || $rose(ide_wr)) |-> $past(ide_cs0 || ide_cs1)); // R10

endmodule

// File: rtl/ide_sector_reader.sv
module ide_sector_reader
    import ide_rd_pkg::*;
#(
    parameter int TRK_W        = 16,
    parameter int SEC_W        = 8,
    parameter int TRK_LOW_W    = 8,
    parameter int SPT_LOG2     = 6,
    parameter int WORDS        = 256,
    parameter int STB_CYC      = 2,
    parameter int RST_CYC      = 32,
    parameter int POST_RST_CYC = 3_200_000,
    parameter int POLL_MAX     = 65_025,
    parameter int LOGIN_POLLS  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TRK_W-1:0] req_track,
    input  logic [SEC_W-1:0] req_sector,
    output logic             req_ready,
    output logic             done,
    output logic             done_err,
    output logic             login_fail,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic [2:0]       ide_addr,
    output logic             ide_cs0,
    output logic             ide_cs1,
    output logic             ide_rd,
    output logic             ide_wr,
    output logic             ide_rst,
    output logic [15:0]      ide_dout,
    output logic             ide_doe,
    input  logic [15:0]      ide_din
);
    localparam int LBA_W   = 16;
    localparam int MAX_A   = (RST_CYC > POST_RST_CYC) ? RST_CYC : POST_RST_CYC;
    localparam int MAX_B   = (POLL_MAX > LOGIN_POLLS) ? POLL_MAX : LOGIN_POLLS;
    localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int WIDX_W  = $clog2(WORDS);

    seq_state_t        state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_step;
    logic [WIDX_W-1:0] widx;
    logic [LBA_W-1:0]  lba_w, lba_q;
    logic [15:0]       word_q;
    logic              err_q, set_err;
    logic              waiting;
    logic              bus_state, bus_go, bus_done;
    bus_req_t          bus_req;
    logic [15:0]       bus_rdata;
    logic              unused_trk_hi;

    assign unused_trk_hi = ^req_track[TRK_W-1:TRK_LOW_W];

    ide_lba_map #(
        .TRK_LOW_W (TRK_LOW_W),
        .SPT_LOG2  (SPT_LOG2),
        .SEC_W     (SEC_W),
        .LBA_W     (LBA_W)
    ) u_lba (
        .trk_low (req_track[TRK_LOW_W-1:0]),
        .sec     (req_sector),
        .lba     (lba_w)
    );

    ide_bus_cycle #(.STB_CYC(STB_CYC)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (bus_go),
        .req      (bus_req),
        .rdata    (bus_rdata),
        .done     (bus_done),
        .ide_addr (ide_addr),
        .ide_cs0  (ide_cs0),
        .ide_cs1  (ide_cs1),
        .ide_rd   (ide_rd),
        .ide_wr   (ide_wr),
        .ide_dout (ide_dout),
        .ide_doe  (ide_doe),
        .ide_din  (ide_din)
    );

    // next state
    always_comb begin
        state_n  = state;
        set_err  = 1'b0;
        cnt_step = bus_done;
        unique case (state)
            S_RST_PULSE: begin
                cnt_step = 1'b1;
                if (cnt == CNT_W'(RST_CYC - 1)) state_n = S_RST_WAIT;
            end
            S_RST_WAIT: begin
                cnt_step = 1'b1;
                if (cnt == CNT_W'(POST_RST_CYC - 1)) state_n = S_LOGIN_SDH;
            end
            S_LOGIN_SDH:  if (bus_done) state_n = S_LOGIN_POLL;
            S_LOGIN_POLL: begin
                if (bus_done) begin
                    if (!bus_rdata[ST_BSY])                    state_n = S_IDLE;
                    else if (cnt == CNT_W'(LOGIN_POLLS - 1))   state_n = S_DEAD;
                end
            end
            S_DEAD:       state_n = S_DEAD;
            S_IDLE:       if (req_valid) state_n = S_PROG;
            S_PROG:       if (bus_done && cnt == CNT_W'(3)) state_n = S_WAIT_RDY;
            S_WAIT_RDY: begin
                if (bus_done) begin
                    if (bus_rdata[ST_BSY:ST_RDY] == 2'b01) state_n = S_CMD;
                    else if (cnt == CNT_W'(POLL_MAX - 1)) begin
                        state_n = S_DONE;
                        set_err = 1'b1;
                    end
                end
            end
            S_CMD:        if (bus_done) state_n = S_WAIT_DRQ;
            S_WAIT_DRQ: begin
                if (bus_done) begin
                    if (!bus_rdata[ST_BSY] && bus_rdata[ST_DRQ]) state_n = S_RD_WORD;
                    else if (cnt == CNT_W'(POLL_MAX - 1)) begin
                        state_n = S_DONE;
                        set_err = 1'b1;
                    end
                end
            end
            S_RD_WORD:    if (bus_done) state_n = S_EMIT_LO;
            S_EMIT_LO:    if (out_ready) state_n = S_EMIT_HI;
            S_EMIT_HI: begin
                if (out_ready)
                    state_n = (widx == WIDX_W'(WORDS - 1)) ? S_FINAL_STAT : S_RD_WORD;
            end
            S_FINAL_STAT: begin
                if (bus_done) begin
                    state_n = S_DONE;
                    set_err = bus_rdata[ST_ERR];
                end
            end
            S_DONE:       state_n = S_IDLE;
            default:      state_n = S_RST_PULSE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_RST_PULSE;
            cnt     <= '0;
            widx    <= '0;
            lba_q   <= '0;
            word_q  <= '0;
            err_q   <= 1'b0;
            waiting <= 1'b0;
        end else begin
            state <= state_n;
            if (state_n != state) cnt <= '0;
            else if (cnt_step)    cnt <= cnt + CNT_W'(1);
            if (state == S_IDLE && req_valid) lba_q <= lba_w;
            if (state == S_IDLE)                      widx <= '0;
            else if (state == S_EMIT_HI && out_ready) widx <= widx + WIDX_W'(1);
            if (state == S_RD_WORD && bus_done) word_q <= bus_rdata;
            if (state == S_IDLE)  err_q <= 1'b0;
            else if (set_err)     err_q <= 1'b1;
            if (bus_go)           waiting <= 1'b1;
            else if (bus_done)    waiting <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        bus_state = 1'b0;
        bus_req   = '0;
        unique case (state)
            S_LOGIN_SDH: begin
                bus_state = 1'b1;
                bus_req   = '{wr: 1'b1, alt: 1'b0, a: TF_DRVHD, wdata: {8'h00, DRVHD_MASTER}};
            end
            S_LOGIN_POLL, S_WAIT_RDY, S_WAIT_DRQ, S_FINAL_STAT: begin
                bus_state = 1'b1;
                bus_req   = '{wr: 1'b0, alt: 1'b0, a: TF_CMDST, wdata: 16'h0000};
            end
            S_PROG: begin
                bus_state = 1'b1;
                unique case (cnt[1:0])
                    2'd0:    bus_req = '{wr: 1'b1, alt: 1'b0, a: TF_CYLHI,  wdata: 16'h0000};
                    2'd1:    bus_req = '{wr: 1'b1, alt: 1'b0, a: TF_CYLLO,  wdata: {8'h00, lba_q[15:8]}};
                    2'd2:    bus_req = '{wr: 1'b1, alt: 1'b0, a: TF_SECNUM, wdata: {8'h00, lba_q[7:0]}};
                    default: bus_req = '{wr: 1'b1, alt: 1'b0, a: TF_SECCNT, wdata: 16'h0001};
                endcase
            end
            S_CMD: begin
                bus_state = 1'b1;
                bus_req   = '{wr: 1'b1, alt: 1'b0, a: TF_CMDST, wdata: {8'h00, OP_READ_SECT}};
            end
            S_RD_WORD: begin
                bus_state = 1'b1;
                bus_req   = '{wr: 1'b0, alt: 1'b0, a: TF_DATA, wdata: 16'h0000};
            end
            default: begin
                bus_state = 1'b0;
                bus_req   = '0;
            end
        endcase
        bus_go     = bus_state && !waiting;
        ide_rst    = (state == S_RST_PULSE);
        req_ready  = (state == S_IDLE);
        login_fail = (state == S_DEAD);
        done       = (state == S_DONE);
        done_err   = (state == S_DONE) && err_q;
        out_valid  = (state == S_EMIT_LO) || (state == S_EMIT_HI);
        out_byte   = (state == S_EMIT_HI) ? word_q[15:8] : word_q[7:0];
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R7
    AST_NO_STROBE_WHILE_BYTE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(ide_rd || ide_wr)); // R7
    AST_CMD_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n) (state == S_CMD && $past(state) == S_WAIT_RDY) |-> (bus_rdata[ST_BSY:ST_RDY] == 2'b01)); // R4
    AST_DATA_AFTER_DRQ: assert property (@(posedge clk) disable iff (!rst_n) (state == S_RD_WORD && $past(state) == S_WAIT_DRQ) |-> (!bus_rdata[ST_BSY] && bus_rdata[ST_DRQ])); // R5
    AST_ERR_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (done && $past(state) == S_FINAL_STAT) |-> (done_err == bus_rdata[ST_ERR])); // R8
    AST_RST_ONLY_IN_BRINGUP: assert property (@(posedge clk) disable iff (!rst_n) (req_ready || login_fail) |-> !ide_rst); // R1

endmodule

// File: tb/ide_sector_reader_bench.sv
module ide_sector_reader_bench;

    localparam int STB    = 2;
    localparam int RSTC   = 8;
    localparam int POSTC  = 20;
    localparam int POLLS  = 16;
    localparam int LPOLLS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_track = '0;
    logic [7:0]  req_sector = '0;
    logic        req_ready, done, done_err, login_fail, out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;
    logic [2:0]  ide_addr;
    logic        ide_cs0, ide_cs1, ide_rd, ide_wr, ide_rst, ide_doe;
    logic [15:0] ide_dout, ide_din;

    always #5 clk = ~clk;

    ide_sector_reader #(
        .STB_CYC(STB), .RST_CYC(RSTC), .POST_RST_CYC(POSTC),
        .POLL_MAX(POLLS), .LOGIN_POLLS(LPOLLS)
    ) u_ide_sector_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_track(req_track),
        .req_sector(req_sector), .req_ready(req_ready), .done(done), .done_err(done_err),
        .login_fail(login_fail), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .ide_addr(ide_addr), .ide_cs0(ide_cs0), .ide_cs1(ide_cs1),
        .ide_rd(ide_rd), .ide_wr(ide_wr), .ide_rst(ide_rst), .ide_dout(ide_dout),
        .ide_doe(ide_doe), .ide_din(ide_din)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0]  tf [8];
    int          busy_left = 0;
    int          drq_delay = 0;
    int          words_left = 0;
    int          data_reads = 0;
    bit          cmd_on = 0, never_rdy = 0, no_drq = 0, fin_err = 0, stuck = 0;
    logic [11:0] wlog [$];
    logic [7:0]  stat_v;
    logic [7:0]  widx_m;

    initial for (int i = 0; i < 8; i++) tf[i] = 8'h00;

    always_comb begin
        widx_m = 8'(256 - words_left);
        if (stuck || busy_left > 0) stat_v = 8'h80;
        else if (never_rdy)         stat_v = 8'h00;
        else begin
            stat_v = 8'h40;
            if (cmd_on && words_left > 0 && !no_drq) stat_v[3] = 1'b1;
            if (cmd_on && words_left == 0 && fin_err) stat_v[0] = 1'b1;
        end
        if (ide_cs0 && ide_addr == 3'd7)      ide_din = {8'h00, stat_v};
        else if (ide_cs0 && ide_addr == 3'd0) ide_din = {widx_m ^ tf[4], widx_m + tf[3]};
        else                                  ide_din = 16'h0000;
    end

    always @(negedge ide_rd) begin
        if (ide_cs0 === 1'b1) begin
            if (ide_addr == 3'd7 && busy_left > 0) busy_left--;
            if (ide_addr == 3'd0) begin
                data_reads++;
                if (words_left > 0) words_left--;
            end
        end
    end

    always @(negedge ide_wr) begin
        if (ide_cs0 === 1'b1) begin
            wlog.push_back({1'b0, ide_addr, ide_dout[7:0]});
            tf[ide_addr] = ide_dout[7:0];
            if (ide_addr == 3'd7 && ide_dout[7:0] == 8'h20) begin
                cmd_on = 1;
                words_left = 256;
                busy_left = drq_delay;
            end
        end
    end

    // ---------------- scoreboard and monitors ----------------
    logic [7:0] sb [$];
    int  popped = 0;
    int  done_cnt = 0;
    bit  last_err = 0;
    bit  prev_stall = 0;
    logic [7:0] prev_byte = '0;
    bit  ready_mode = 0;
    logic [4:0] lfsr = 5'h15;
    int  strb_run = 0, hold_run = 0, strb_bad = 0, strb_seen = 0;
    bit  in_hold = 0;

    always @(posedge clk) begin
        lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
        out_ready <= ready_mode ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && out_byte == prev_byte, "R7 stalled byte held", int'(out_byte), int'(prev_byte));
            if (out_valid && (ide_rd || ide_wr))
                chk(0, "R7 strobe while byte waits", 1, 0);
            if (out_valid && out_ready) begin
                if (sb.size() == 0) chk(0, "R6 unexpected byte", int'(out_byte), -1);
                else begin
                    logic [7:0] e;
                    e = sb.pop_front();
                    chk(out_byte == e, "R6 byte order/value", int'(out_byte), int'(e));
                    popped++;
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
            if (done) begin
                done_cnt++;
                last_err = done_err;
            end
            if (ide_rd || ide_wr) begin
                strb_run++;
                in_hold = 0;
            end else begin
                if (strb_run > 0) begin
                    if (strb_run != STB) strb_bad++;
                    strb_seen++;
                    strb_run = 0;
                    in_hold = 1;
                    hold_run = 0;
                end
                if (in_hold) begin
                    if (ide_cs0 || ide_cs1) hold_run++;
                    else begin
                        if (hold_run != STB) strb_bad++;
                        in_hold = 0;
                    end
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R9 watchdog: actual no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- driver ----------------
    task automatic do_read(input logic [15:0] trk, input logic [7:0] sec,
                           input int pre_busy, input int drq_dly,
                           input bit nrdy, input bit ndrq, input bit ferr,
                           input bit stall, input bit poke);
        int  l;
        bit  want_data;
        bit  want_err;
        l = int'(trk[7:0]) * 64 + int'(sec);
        want_data = !nrdy && !ndrq;
        want_err  = nrdy || ndrq || ferr;
        never_rdy = nrdy; no_drq = ndrq; fin_err = ferr;
        busy_left = pre_busy; drq_delay = drq_dly; ready_mode = stall;
        wlog.delete(); done_cnt = 0; data_reads = 0; popped = 0;
        if (want_data)
            for (int i = 0; i < 256; i++) begin
                sb.push_back(8'(i + (l & 255)));
                sb.push_back(8'(i) ^ 8'(l >> 8));
            end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_track = trk; req_sector = sec; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_track = ~trk; req_sector = ~sec; req_valid = 1'b1;
            repeat (30) @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9 one done per request", done_cnt, 1);
        chk(last_err == want_err, nrdy ? "R4 ready timeout error" : ndrq ? "R5 drq timeout error" : "R8 final status error flag",
            int'(last_err), int'(want_err));
        chk(wlog.size() == (nrdy ? 4 : 5), nrdy ? "R4 no command written" : "R4 write count", wlog.size(), nrdy ? 4 : 5);
        if (wlog.size() >= 4) begin
            chk(wlog[0] == {4'h5, 8'h00}, "R3 cylinder high", int'(wlog[0]), 12'h500);
            chk(wlog[1] == {4'h4, 8'(l >> 8)}, "R3 cylinder low", int'(wlog[1]), int'({4'h4, 8'(l >> 8)}));
            chk(wlog[2] == {4'h3, 8'(l)}, "R3 sector number", int'(wlog[2]), int'({4'h3, 8'(l)}));
            chk(wlog[3] == {4'h2, 8'h01}, "R3 sector count", int'(wlog[3]), 12'h201);
        end
        if (wlog.size() == 5)
            chk(wlog[4] == {4'h7, 8'h20}, "R4 read command", int'(wlog[4]), 12'h720);
        chk(popped == (want_data ? 512 : 0), "R6 byte count", popped, want_data ? 512 : 0);
        chk(data_reads == (want_data ? 256 : 0), ndrq ? "R5 no data reads" : "R6 word reads", data_reads, want_data ? 256 : 0);
        sb.delete();
    endtask

    initial begin
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!req_ready && !out_valid && !done && !login_fail, "R1 reset state", int'({req_ready, out_valid, done, login_fail}), 0);
        wlog.delete();
        rst_n = 1'b1;
        n = 0;
        while (ide_rst) begin
            @(negedge clk);
            n++;
        end
        chk(n == RSTC, "R1 reset pulse width", n, RSTC);
        while (!req_ready && !login_fail) @(negedge clk);
        chk(req_ready && !login_fail, "R1 bring-up completes", int'(req_ready), 1);
        chk(wlog.size() == 1 && wlog[0] == {4'h6, 8'hE0}, "R1 drive/head write", wlog.size() > 0 ? int'(wlog[0]) : -1, 12'h6E0);

        do_read(16'h5A03, 8'h05, 0, 2, 0, 0, 0, 0, 0);  // R3: high track byte ignored, addr 0x00C5
        do_read(16'h00FF, 8'h3F, 5, 7, 0, 0, 0, 1, 0);  // R4 R5 R7: busy polls and stalls, addr 0x3FFF
        do_read(16'h0001, 8'h10, 0, 1, 0, 0, 0, 0, 1);  // R9: request pokes while busy
        do_read(16'h0002, 8'h00, 0, 0, 1, 0, 0, 0, 0);  // R4: never ready
        do_read(16'h0004, 8'h01, 0, 0, 0, 1, 0, 0, 0);  // R5: no data request
        do_read(16'h0080, 8'hFF, 0, 3, 0, 0, 1, 1, 0);  // R8: error bit after data

        chk(strb_bad == 0 && strb_seen > 0, "R10 strobe and hold widths", strb_bad, 0);

        // R2: device never leaves busy during bring-up
        stuck = 1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        wlog.delete();
        done_cnt = 0;
        rst_n = 1'b1;
        repeat (RSTC + POSTC + LPOLLS * (3 * STB + 2) + 60) @(negedge clk);
        chk(login_fail && !req_ready, "R2 bring-up failure flagged", int'({login_fail, req_ready}), 2);
        req_valid = 1'b1;
        repeat (40) @(negedge clk);
        req_valid = 1'b0;
        chk(done_cnt == 0 && !req_ready, "R2 requests refused after failure", done_cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule